// File: doc/BRIEF.md
# Serial NOR Flash Operation Sequencer

The sequencer turns a single request (operation code, 24-bit address, byte count) into the complete series of SPI frames that a serial NOR flash needs for that operation. It can read the three-byte identification, read any number of data bytes, program a run of bytes and erase one sector. It contains its own byte-wide SPI master. That master runs with the clock idling low and sends the most significant bit first. The master changes the output data on the falling SCK edge and samples input data on the rising edge. The SCK half period is a parameter counted in system clocks.

For a program or an erase, the sequencer first sends a write-enable frame by itself. After the modifying frame it opens a status frame and keeps reading status bytes until the device reports that it is idle. Only then does it report completion. Chip select is held high for at least one SCK period between any two frames, and this includes the frames of back-to-back requests. Program data is pulled from the user one byte at a time with a take strobe. Read data is handed out one byte at a time with a valid strobe. The identification is returned as a 24-bit word that stays valid when done pulses.

The controller states are IDLE, WREN, GAP, OPC, ADDR, XFER, POLL_CMD, POLL_RD and DONE. IDLE accepts a request and goes to WREN for a program or erase, and to OPC otherwise. WREN goes to GAP and then to OPC. OPC goes to XFER for an identification read and to ADDR for the other operations. ADDR sends three bytes and then goes to one of three places: GAP then POLL_CMD for an erase, XFER when bytes remain, or GAP when the count is zero. XFER goes to GAP after its last byte. GAP waits out the deselect time and continues to the stored follow-on state: OPC, POLL_CMD or DONE. POLL_CMD goes to POLL_RD. POLL_RD repeats while the busy bit is set, and goes to GAP and then DONE once the bit is clear. DONE returns to IDLE.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sck is 0, req_ready is 1 and done is 0.
- R2: SCK idles low and toggles only while spi_cs_n is 0. Every byte goes out most significant bit first. MOSI changes only after falling SCK edges and MISO is sampled on rising edges.
- R3: req_op 0 sends one frame made of 0x9F and three 0xFF bytes. id_out then holds the three received bytes, the first in bits 23:16, the second in bits 15:8 and the third in bits 7:0.
- R4: req_op 1 sends one frame made of 0x03, then the address with bits 23:16 first, then req_len filler bytes of 0xFF. Each received byte appears on rd_data with a one-cycle rd_valid. A count of zero gives no data phase.
- R5: req_op 2 sends a frame holding only 0x06. It then sends a frame of 0x02, the address (high byte first) and req_len bytes taken from wr_data. wr_take pulses once per byte, in the cycle that wr_data is consumed.
- R6: req_op 3 sends a frame holding only 0x06, then a frame of 0x20 and the three address bytes with the high byte first.
- R7: After the program or erase frame, a frame with 0x05 follows. In that frame 0xFF bytes are read until a received byte has bit 0 clear. Other status bits are ignored.
- R8: Between any two frames spi_cs_n stays high for at least 2*HALF_DIV clock cycles.
- R9: done is a one-cycle pulse, raised only while spi_cs_n is high and after the last frame. req_ready is low from acceptance until done. A request presented while busy causes no frame and no second done.
- R10: The operation encoding is 0 for the identification read, 1 for a read, 2 for a program and 3 for an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when req_ready is 1 |
| req_op | input | 2 | Operation code (see R10) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Data byte count for read or program |
| req_ready | output | 1 | Sequencer idle, a request can be taken |
| wr_data | input | 8 | Program byte offered to the sequencer |
| wr_take | output | 1 | Current wr_data byte consumed |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| id_out | output | 24 | Packed identification bytes |
| done | output | 1 | Operation finished, one-cycle pulse |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench connects a behavioural flash model to the serial pins. A scoreboard compares every byte the model receives, and every frame boundary, against the expected frame list for each request. Identification reads and reads of preloaded, programmed and erased regions tell apart wrong byte order, wrong address order and wrong data path selection. A zero-length read and a program followed by a read-back separate the data phase from the address phase. The model reports busy for several status bytes while other status bits stay set. This shows whether polling keys on bit 0 alone and whether done waits for the idle status. A request pulsed in the middle of an operation shows whether requests are refused while busy.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_ID    = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } nor_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WREN,
        S_GAP,
        S_OPC,
        S_ADDR,
        S_XFER,
        S_POLL_CMD,
        S_POLL_RD,
        S_DONE
    } seq_state_e;

    localparam logic [7:0] CODE_ID     = 8'h9F;
    localparam logic [7:0] CODE_READ   = 8'h03;
    localparam logic [7:0] CODE_PROG   = 8'h02;
    localparam logic [7:0] CODE_ERASE  = 8'h20;
    localparam logic [7:0] CODE_WREN   = 8'h06;
    localparam logic [7:0] CODE_STATUS = 8'h05;
    localparam logic [7:0] FILLER      = 8'hFF;
    localparam int         BUSY_BIT    = 0;
    localparam int         ADDR_BYTES  = 3;

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(HALF_DIV - 1);

    logic          active;
    logic          sck_q;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            sck_q  <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                tx_sh  <= tx_byte;
                cnt    <= '0;
                bitn   <= '0;
                sck_q  <= 1'b0;
            end else if (active) begin
                if (cnt == CNT_END) begin
                    cnt <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            tx_sh <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign busy    = active;
    assign done    = done_q;
    assign rx_byte = rx_sh;
    assign sck     = sck_q;
    assign mosi    = tx_sh[7];

    // R2: data out must hold while SCK is high
    assert_mosi_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi));

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
#(
    parameter int LEN_W    = 9,
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic [23:0]      id_out,
    output logic             done,
    output logic             cs_n,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx
);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_END = GW'(GAP_CYC - 1);

    seq_state_e       state;
    seq_state_e       gap_next;
    nor_op_e          op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] left_q;
    logic [1:0]       idx;
    logic             issued;
    logic [GW-1:0]    gapc;
    logic [23:0]      id_q;
    logic [7:0]       rd_q;
    logic             rd_v_q;
    logic             in_frame;
    logic             byte_fin;
    logic [7:0]       opcode;
    logic [7:0]       addr_byte;

    // ---------------- outputs ----------------
    always_comb begin
        in_frame = (state == S_WREN) || (state == S_OPC) || (state == S_ADDR) ||
                   (state == S_XFER) || (state == S_POLL_CMD) || (state == S_POLL_RD);
        unique case (op_q)
            OP_ID:    opcode = CODE_ID;
            OP_READ:  opcode = CODE_READ;
            OP_PROG:  opcode = CODE_PROG;
            OP_ERASE: opcode = CODE_ERASE;
            default:  opcode = CODE_ID;
        endcase
        unique case (idx)
            2'd0:    addr_byte = addr_q[23:16];
            2'd1:    addr_byte = addr_q[15:8];
            default: addr_byte = addr_q[7:0];
        endcase
        unique case (state)
            S_WREN:     eng_tx = CODE_WREN;
            S_OPC:      eng_tx = opcode;
            S_ADDR:     eng_tx = addr_byte;
            S_XFER:     eng_tx = (op_q == OP_PROG) ? wr_data : FILLER;
            S_POLL_CMD: eng_tx = CODE_STATUS;
            default:    eng_tx = FILLER;
        endcase
        cs_n      = !in_frame;
        eng_start = in_frame && !issued;
        wr_take   = eng_start && (state == S_XFER) && (op_q == OP_PROG);
        byte_fin  = in_frame && issued && eng_done;
        req_ready = (state == S_IDLE);
        done      = (state == S_DONE);
        rd_data   = rd_q;
        rd_valid  = rd_v_q;
        id_out    = id_q;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            gap_next <= S_IDLE;
            op_q     <= OP_ID;
            addr_q   <= '0;
            left_q   <= '0;
            idx      <= '0;
            issued   <= 1'b0;
            gapc     <= '0;
            id_q     <= '0;
            rd_q     <= '0;
            rd_v_q   <= 1'b0;
        end else begin
            rd_v_q <= 1'b0;
            if (eng_start) begin
                issued <= 1'b1;
            end
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q   <= nor_op_e'(req_op);
                        addr_q <= req_addr;
                        idx    <= '0;
                        issued <= 1'b0;
                        if (nor_op_e'(req_op) == OP_ID) begin
                            left_q <= LEN_W'(ADDR_BYTES);
                        end else begin
                            left_q <= req_len;
                        end
                        if ((nor_op_e'(req_op) == OP_PROG) || (nor_op_e'(req_op) == OP_ERASE)) begin
                            state <= S_WREN;
                        end else begin
                            state <= S_OPC;
                        end
                    end
                end
                S_WREN: begin
                    if (byte_fin) begin
                        issued   <= 1'b0;
                        state    <= S_GAP;
                        gap_next <= S_OPC;
                    end
                end
                S_GAP: begin
                    if (gapc == GAP_END) begin
                        gapc  <= '0;
                        state <= gap_next;
                    end else begin
                        gapc <= gapc + GW'(1);
                    end
                end
                S_OPC: begin
                    if (byte_fin) begin
                        issued <= 1'b0;
                        idx    <= '0;
                        state  <= (op_q == OP_ID) ? S_XFER : S_ADDR;
                    end
                end
                S_ADDR: begin
                    if (byte_fin) begin
                        issued <= 1'b0;
                        if (idx == 2'(ADDR_BYTES - 1)) begin
                            if (op_q == OP_ERASE) begin
                                state    <= S_GAP;
                                gap_next <= S_POLL_CMD;
                            end else if (left_q == '0) begin
                                state    <= S_GAP;
                                gap_next <= (op_q == OP_PROG) ? S_POLL_CMD : S_DONE;
                            end else begin
                                state <= S_XFER;
                            end
                        end else begin
                            idx <= idx + 2'd1;
                        end
                    end
                end
                S_XFER: begin
                    if (byte_fin) begin
                        issued <= 1'b0;
                        left_q <= left_q - LEN_W'(1);
                        if (op_q == OP_ID) begin
                            id_q <= {id_q[15:0], eng_rx};
                        end
                        if (op_q == OP_READ) begin
                            rd_q   <= eng_rx;
                            rd_v_q <= 1'b1;
                        end
                        if (left_q == LEN_W'(1)) begin
                            state    <= S_GAP;
                            gap_next <= (op_q == OP_PROG) ? S_POLL_CMD : S_DONE;
                        end
                    end
                end
                S_POLL_CMD: begin
                    if (byte_fin) begin
                        issued <= 1'b0;
                        state  <= S_POLL_RD;
                    end
                end
                S_POLL_RD: begin
                    if (byte_fin) begin
                        issued <= 1'b0;
                        if (!eng_rx[BUSY_BIT]) begin
                            state    <= S_GAP;
                            gap_next <= S_DONE;
                        end
                    end
                end
                S_DONE: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: a byte is launched only into an idle shifter
    assert_start_engine_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

    // R8: a deselect lasts more than one cycle
    assert_gap_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R9: completion is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: read bytes are only delivered during a read
    assert_rd_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (op_q == OP_READ));

    // R7: a busy status keeps the poll going
    assert_poll_stays_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POLL_RD && byte_fin && eng_rx[BUSY_BIT]) |=> (state == S_POLL_RD));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
    parameter int LEN_W    = 9,
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic [23:0]      id_out,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_busy;
    logic       eng_done;
    logic [7:0] eng_rx;

    nor_seq_fsm #(
        .LEN_W    (LEN_W),
        .HALF_DIV (HALF_DIV)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_ready (req_ready),
        .wr_data   (wr_data),
        .wr_take   (wr_take),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .id_out    (id_out),
        .done      (done),
        .cs_n      (spi_cs_n),
        .eng_start (eng_start),
        .eng_tx    (eng_tx),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx)
    );

    spi_byte_engine #(
        .HALF_DIV (HALF_DIV)
    ) i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    // R2: no SCK activity while the flash is deselected
    assert_sck_low_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

endmodule

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;
    localparam int LEN_W    = 9;
    localparam int HALF_DIV = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = '0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_ready;
    logic [7:0]       wr_data = '0;
    logic             wr_take;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic [23:0]      id_out;
    logic             done;
    logic             spi_cs_n;
    logic             spi_sck;
    logic             spi_mosi;
    logic             spi_miso;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    nor_cmd_seq #(.LEN_W(LEN_W), .HALF_DIV(HALF_DIV)) i_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .id_out(id_out), .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- scoreboard queues ----------------
    int    exp_q[$];     // byte values, -1 marks end of frame
    string exp_tag[$];
    int    exp_rd[$];
    logic [7:0] shadow[256];

    task automatic eb(input int v, input string t);
        exp_q.push_back(v);
        exp_tag.push_back(t);
    endtask

    task automatic ef(input string t);
        exp_q.push_back(-1);
        exp_tag.push_back(t);
    endtask

    // ---------------- flash model ----------------
    logic [7:0] fmem[256];
    logic [7:0] frame[$];
    logic [7:0] sh_in = '0;
    logic [7:0] sh_out = 8'hFF;
    logic [7:0] nxt = 8'hFF;
    int bitc = 0;
    int fcnt = 0;
    int busy_left = 0;
    bit wel = 1'b0;
    int frames_seen = 0;

    assign spi_miso = spi_cs_n ? 1'b0 : sh_out[7];

    function automatic logic [7:0] id_byte(input int n);
        case (n)
            1:       return 8'hC2;
            2:       return 8'h25;
            3:       return 8'h36;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic byte_in(input logic [7:0] b);
        int n;
        int e;
        string t;
        frame.push_back(b);
        n = frame.size();
        if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected byte", int'(b), -1);
        end else begin
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            check(e == int'(b), t, int'(b), e);
        end
        nxt = 8'hFF;
        case (frame[0])
            8'h9F: nxt = id_byte(n);
            8'h03: if (n >= 4) nxt = fmem[8'(int'(frame[3]) + n - 4)];
            8'h05: begin
                if (busy_left > 0) begin
                    nxt = 8'h03;   // busy with other bit set
                    busy_left--;
                end else begin
                    nxt = 8'h02;   // idle, other bit still set
                end
            end
            default: nxt = 8'hFF;
        endcase
    endtask

    always @(negedge spi_cs_n) begin
        frame.delete();
        bitc   = 0;
        fcnt   = 0;
        sh_out = 8'hFF;
    end

    always @(posedge spi_cs_n) begin
        if (frame.size() > 0) begin
            int e;
            string t;
            frames_seen++;
            check(spi_sck == 1'b0, "R2 sck low at deselect", int'(spi_sck), 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected frame end", 0, -1);
            end else begin
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(e == -1, t, -1, e);
            end
            if (frame[0] == 8'h06) wel = 1'b1;
            if (frame[0] == 8'h02 && wel) begin
                for (int k = 4; k < frame.size(); k++) fmem[8'(int'(frame[3]) + k - 4)] = frame[k];
                busy_left = 3;
                wel = 1'b0;
            end
            if (frame[0] == 8'h20 && wel) begin
                for (int k = 0; k < 256; k++) fmem[k] = 8'hFF;
                busy_left = 3;
                wel = 1'b0;
            end
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sh_in = {sh_in[6:0], spi_mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                byte_in(sh_in);
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            fcnt++;
            if (fcnt == 8) begin
                fcnt   = 0;
                sh_out = nxt;
            end else begin
                sh_out = {sh_out[6:0], 1'b1};
            end
        end
    end

    // ---------------- monitors ----------------
    int  hi_cnt = 0;
    bit  prev_cs = 1'b1;
    bit  had_frame = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && prev_cs) begin
                if (had_frame) check(hi_cnt >= 2 * HALF_DIV, "R8 deselect gap", hi_cnt, 2 * HALF_DIV);
                had_frame = 1'b1;
            end
            hi_cnt  = spi_cs_n ? hi_cnt + 1 : 0;
            prev_cs = spi_cs_n;
            if (rd_valid) begin
                if (exp_rd.size() == 0) check(1'b0, "R4 unexpected read byte", int'(rd_data), -1);
                else begin
                    int e;
                    e = exp_rd.pop_front();
                    check(int'(rd_data) == e, "R4 read data", int'(rd_data), e);
                end
            end
        end
    end

    logic [7:0] pbuf[$];
    int take_cnt = 0;
    always @(posedge clk) begin
        if (wr_take) begin
            take_cnt++;
            wr_data <= (take_cnt < pbuf.size()) ? pbuf[take_cnt] : 8'h00;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input int op, input int addr, input int len, input bit poke_busy);
        int waitc;
        bit seen_done;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_addr  = 24'(addr);
        req_len   = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 ready low while busy", int'(req_ready), 0);
        if (poke_busy) begin
            repeat (30) @(negedge clk);
            req_valid = 1'b1;
            req_op    = 2'd3;
            req_addr  = 24'h000000;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        seen_done = 1'b0;
        waitc = 0;
        while (!seen_done && waitc < 20000) begin
            @(negedge clk);
            waitc++;
            if (done) seen_done = 1'b1;
        end
        check(seen_done, "R9 done seen", int'(seen_done), 1);
        check(spi_cs_n == 1'b1, "R9 deselected at done", int'(spi_cs_n), 1);
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R9 single done pulse", int'(done), 0);
        check(exp_q.size() == 0, "R7 all frames seen", exp_q.size(), 0);
    endtask

    task automatic exp_status(input string t);
        eb(8'h05, t);
        for (int k = 0; k < 4; k++) eb(8'hFF, t);
        ef(t);
    endtask

    task automatic do_read(input int addr, input int len, input bit poke);
        eb(8'h03, "R4 opcode");
        eb((addr >> 16) & 255, "R4 addr hi");
        eb((addr >> 8) & 255, "R4 addr mid");
        eb(addr & 255, "R4 addr lo");
        for (int k = 0; k < len; k++) begin
            eb(8'hFF, "R4 filler");
            exp_rd.push_back(int'(shadow[8'(addr + k)]));
        end
        ef("R4 frame end");
        issue(1, addr, len, poke);
        check(exp_rd.size() == 0, "R4 read count", exp_rd.size(), 0);
    endtask

    task automatic do_prog(input int addr, input int len, input int seed);
        pbuf.delete();
        for (int k = 0; k < len; k++) pbuf.push_back(8'((seed + 37 * k) & 255));
        take_cnt = 0;
        wr_data  = (len > 0) ? pbuf[0] : 8'h00;
        eb(8'h06, "R5 write enable");
        ef("R5 wren frame end");
        eb(8'h02, "R5 opcode");
        eb((addr >> 16) & 255, "R5 addr hi");
        eb((addr >> 8) & 255, "R5 addr mid");
        eb(addr & 255, "R5 addr lo");
        for (int k = 0; k < len; k++) begin
            eb(int'(pbuf[k]), "R5 program data");
            shadow[8'(addr + k)] = pbuf[k];
        end
        ef("R5 frame end");
        exp_status("R7 status poll");
        issue(2, addr, len, 1'b0);
        check(take_cnt == len, "R5 take count", take_cnt, len);
    endtask

    task automatic do_erase(input int addr);
        eb(8'h06, "R6 write enable");
        ef("R6 wren frame end");
        eb(8'h20, "R6 opcode");
        eb((addr >> 16) & 255, "R6 addr hi");
        eb((addr >> 8) & 255, "R6 addr mid");
        eb(addr & 255, "R6 addr lo");
        ef("R6 frame end");
        exp_status("R7 status poll");
        for (int k = 0; k < 256; k++) shadow[k] = 8'hFF;
        issue(3, addr, 0, 1'b0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int fr;
        for (int k = 0; k < 256; k++) begin
            fmem[k]   = 8'(k ^ 8'h5A);
            shadow[k] = 8'(k ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 reset pins", {spi_cs_n, spi_sck}, 2);
        check(req_ready == 1'b1 && done == 1'b0, "R1 reset handshake", {req_ready, done}, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 / R10 identification read
        eb(8'h9F, "R3 opcode");
        for (int k = 0; k < 3; k++) eb(8'hFF, "R3 filler");
        ef("R3 frame end");
        issue(0, 0, 0, 1'b0);
        check(id_out == 24'hC22536, "R3 id packing", int'(id_out), 24'hC22536);

        // R4 read of preloaded data, with a request poked while busy (R9)
        do_read(24'h000010, 6, 1'b1);
        fr = frames_seen;
        repeat (200) @(negedge clk);
        check(frames_seen == fr && spi_cs_n, "R9 busy request ignored", frames_seen, fr);

        // R4 zero-length read
        do_read(24'h0A0B0C, 0, 1'b0);

        // R5 / R7 program then read back
        do_prog(24'h000020, 5, 8'h11);
        do_read(24'h00001E, 9, 1'b0);

        // R6 / R7 erase then read back
        do_erase(24'h001000);
        do_read(24'h000020, 4, 1'b0);

        // R5 program after erase, R10 read back
        do_prog(24'h0000F0, 3, 8'hA0);
        do_read(24'h0000EF, 5, 1'b0);

        finish_run();
    end

endmodule